// File: doc/BRIEF.md
# Host Buffer Controller with DMA Pacing

This block is the host side of a coprocessor. The host fills an input FIFO through a valid/ready stream. The block writes those words, one per cycle, into the coprocessor's internal address space. Writing starts at a programmed start address, and the block stops once a programmed number of words has moved. In the other direction, the block reads a programmed number of words from an internal address range into an output FIFO. The host drains that FIFO through a second valid/ready stream. A word count may be larger than the FIFO, so a transfer simply continues as the FIFOs refill or empty.

Two DMA request lines pace the host:
- The input request stays high while the input FIFO has room.
- The output request stays high while the output FIFO holds data.

Because of this, the host can queue data for the next operation while the current one is still running. A small register file, selected by a 3-bit index, provides the following:
- the start addresses and address-wrap masks;
- the word counts;
- completion status with write-1-to-clear;
- per-source interrupt masks and an auto-unmask option;
- a software reset that takes effect on the clock edge after it is written.

Back-pressure works the same way on both streams. A word moves on a rising edge only when valid and ready are both high. The input stream's ready (`in_ready`) depends only on FIFO fill state. The output stream's data and valid are stable for as long as valid is held. The internal port has no handshake: it accepts a write and returns read data in the same cycle.

Top module: `host_buf_ctrl`

## Requirements
- R1: Registers are selected by `reg_sel`, as follows. A write through `reg_we` takes effect on the next rising edge. `reg_rdata` shows the selected register combinationally.
  - 0: command/status. Bit 0 is input done. Bit 1 is output done. Bit 8 is auto-unmask. Bit 31 is the software reset.
  - 1: read-only ID, equal to `ID_VALUE`.
  - 2: interrupt mask. Bit 0 is input and bit 1 is output; a 1 means masked.
  - 3: input control. Bits [15:0] are the start address and bits [31:16] are the address mask.
  - 4: input count.
  - 5: output control, laid out like input control.
  - 6: output count.
- R2: `dreq_in` and `in_ready` are high exactly when the input FIFO has at least one free word. An input word is accepted on an edge where `in_valid` and `in_ready` are both high.
- R3: `dreq_out` and `out_valid` are high exactly when the output FIFO holds a word. Words leave in the order they were read, one per edge with `out_ready` high.
- R4: While the input count is nonzero and the input FIFO is not empty, the block drives one internal write per cycle. Each write carries the oldest FIFO word. No internal write occurs while the count is zero.
- R5: Writing a control register loads the address pointer from its start field. After each word, the pointer becomes `(a & ~m) | ((a+1) & m)`, so bits outside the mask `m` never change.
- R6: While the output count is nonzero and the output FIFO is not full, the block drives one internal read per cycle. `int_rd_data` is captured in the same cycle.
- R7: Each moved word decrements its count register, and reading the register returns the remaining count. When the count reaches zero, done bit 0 (input) or bit 1 (output) is set. Writing 1 to a done bit clears it.
- R8: `irq` is high exactly when some done bit is set and its mask bit is 0.
- R9: When auto-unmask (bit 8) is 1, a completing operation clears its own mask bit.
- R10: Writing 1 to bit 31 of the command/status register triggers a software reset on the following edge. The reset empties both FIFOs, zeroes both counts and clears both done bits. The ID, mask and control registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 3 | Register index |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register contents |
| in_valid | input | 1 | Input stream word valid |
| in_ready | output | 1 | Input FIFO can take a word |
| in_data | input | 32 | Input stream word |
| out_valid | output | 1 | Output FIFO holds a word |
| out_ready | input | 1 | Host takes the output word |
| out_data | output | 32 | Oldest output word |
| dreq_in | output | 1 | DMA request: input space free |
| dreq_out | output | 1 | DMA request: output data present |
| irq | output | 1 | Unmasked completion interrupt |
| int_wr_en | output | 1 | Internal write strobe |
| int_wr_addr | output | ADDR_W | Internal write address |
| int_wr_data | output | 32 | Internal write data |
| int_rd_en | output | 1 | Internal read strobe |
| int_rd_addr | output | ADDR_W | Internal read address |
| int_rd_data | input | 32 | Internal read data, same cycle |

## Verification
The input path is swept over several address masks and two start addresses, one of which wraps through zero. Each run uses a count of 20 words against an 8-word FIFO, so the address formula, the fixed upper bits and the refill behaviour are all distinguished. A second input pattern fills the FIFO while the count is zero and only then starts the operation. This separates the FIFO-full request from the count-gated drain. The output path is run with the host stalled until the FIFO fills, then drained. This shows the read pause at full, the remaining count and the order of the wrapped addresses. Separate operations with masked, unmasked and auto-unmasked interrupts distinguish status from pin behaviour, and a software reset issued mid-operation shows which state it clears.

// File: rtl/hbc_pkg.sv
package hbc_pkg;
  typedef enum logic [2:0] {
    SEL_CSTAT = 3'd0,
    SEL_ID    = 3'd1,
    SEL_MASK  = 3'd2,
    SEL_ICTL  = 3'd3,
    SEL_ICNT  = 3'd4,
    SEL_OCTL  = 3'd5,
    SEL_OCNT  = 3'd6
  } reg_sel_e;

  localparam int BIT_IN_DONE  = 0;
  localparam int BIT_OUT_DONE = 1;
  localparam int BIT_AUTO     = 8;
  localparam int BIT_SRST     = 31;
  localparam int CTL_MASK_LSB = 16;
  localparam int REG_W        = 32;
endpackage

// File: rtl/hbc_fifo.sv
module hbc_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign rdata = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R2: the caller never pushes into a full FIFO
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R4: the caller never pops an empty FIFO
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/hbc_walker.sv
module hbc_walker #(
  parameter int AW = 16,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_ptr,
  input  logic [AW-1:0] ld_start,
  input  logic [AW-1:0] cmask,
  input  logic          ld_cnt,
  input  logic [CW-1:0] cnt_val,
  input  logic          clr_cnt,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic [CW-1:0] cnt,
  output logic          active,
  output logic          done
);
  logic [AW-1:0] inc;

  assign inc    = addr + 1'b1;
  assign active = (cnt != '0);
  assign done   = step && (cnt == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr <= '0;
    else if (ld_ptr) addr <= ld_start;
    else if (step) addr <= (addr & ~cmask) | (inc & cmask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (clr_cnt) cnt <= '0;
    else if (ld_cnt) cnt <= cnt_val;
    else if (step) cnt <= cnt - 1'b1;
  end

  // R5: bits outside the counter mask hold across a step
  a_r5_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld_ptr) |=> (((addr ^ $past(addr)) & ~$past(cmask)) == '0));
  // R7: an undisturbed step lowers the count by one
  a_r7_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld_cnt && !clr_cnt) |=> (cnt == $past(cnt) - CW'(1)));
  // R4: no word moves on a zero count
  a_r4_step_needs_count: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (cnt != '0));
endmodule

// File: rtl/host_buf_ctrl.sv
module host_buf_ctrl
  import hbc_pkg::*;
#(
  parameter int          DEPTH    = 128,
  parameter int          ADDR_W   = 16,
  parameter logic [31:0] ID_VALUE = 32'h0C0F_FEE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        reg_sel,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [31:0]       out_data,
  output logic              dreq_in,
  output logic              dreq_out,
  output logic              irq,
  output logic              int_wr_en,
  output logic [ADDR_W-1:0] int_wr_addr,
  output logic [31:0]       int_wr_data,
  output logic              int_rd_en,
  output logic [ADDR_W-1:0] int_rd_addr,
  input  logic [31:0]       int_rd_data
);
  localparam int NSRC = 2;

  logic              srst_q, auto_q;
  logic [NSRC-1:0]   status_q, mask_q, done_v;
  logic [31:0]       ictl_q, octl_q;
  logic              wr_cstat, wr_mask, wr_ictl, wr_icnt, wr_octl, wr_ocnt;
  logic              in_full, in_empty, out_full, out_empty;
  logic              i_step, o_step, i_active, o_active, i_done, o_done;
  logic [31:0]       i_cnt, o_cnt;
  logic [ADDR_W-1:0] i_start, o_start;

  assign wr_cstat = reg_we && (reg_sel == SEL_CSTAT);
  assign wr_mask  = reg_we && (reg_sel == SEL_MASK);
  assign wr_ictl  = reg_we && (reg_sel == SEL_ICTL);
  assign wr_icnt  = reg_we && (reg_sel == SEL_ICNT);
  assign wr_octl  = reg_we && (reg_sel == SEL_OCTL);
  assign wr_ocnt  = reg_we && (reg_sel == SEL_OCNT);

  // stream edges and DMA pacing
  assign in_ready  = !in_full;
  assign dreq_in   = !in_full;
  assign out_valid = !out_empty;
  assign dreq_out  = !out_empty;

  // internal port
  assign i_step    = i_active && !in_empty;
  assign o_step    = o_active && !out_full;
  assign int_wr_en = i_step;
  assign int_rd_en = o_step;

  hbc_fifo #(.W(32), .DEPTH(DEPTH)) u_in_fifo (
    .clk(clk), .rst_n(rst_n), .clr(srst_q),
    .push(in_valid && in_ready), .wdata(in_data),
    .pop(i_step), .rdata(int_wr_data),
    .full(in_full), .empty(in_empty)
  );

  hbc_fifo #(.W(32), .DEPTH(DEPTH)) u_out_fifo (
    .clk(clk), .rst_n(rst_n), .clr(srst_q),
    .push(o_step), .wdata(int_rd_data),
    .pop(out_valid && out_ready), .rdata(out_data),
    .full(out_full), .empty(out_empty)
  );

  // a pointer reload comes from the write data, or from the stored field on soft reset
  assign i_start = wr_ictl ? reg_wdata[ADDR_W-1:0] : ictl_q[ADDR_W-1:0];
  assign o_start = wr_octl ? reg_wdata[ADDR_W-1:0] : octl_q[ADDR_W-1:0];

  hbc_walker #(.AW(ADDR_W), .CW(32)) u_in_walk (
    .clk(clk), .rst_n(rst_n),
    .ld_ptr(wr_ictl || srst_q), .ld_start(i_start),
    .cmask(ictl_q[CTL_MASK_LSB +: ADDR_W]),
    .ld_cnt(wr_icnt), .cnt_val(reg_wdata), .clr_cnt(srst_q),
    .step(i_step), .addr(int_wr_addr), .cnt(i_cnt),
    .active(i_active), .done(i_done)
  );

  hbc_walker #(.AW(ADDR_W), .CW(32)) u_out_walk (
    .clk(clk), .rst_n(rst_n),
    .ld_ptr(wr_octl || srst_q), .ld_start(o_start),
    .cmask(octl_q[CTL_MASK_LSB +: ADDR_W]),
    .ld_cnt(wr_ocnt), .cnt_val(reg_wdata), .clr_cnt(srst_q),
    .step(o_step), .addr(int_rd_addr), .cnt(o_cnt),
    .active(o_active), .done(o_done)
  );

  assign done_v = {o_done, i_done};

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_q <= 1'b0;
      auto_q <= 1'b0;
      ictl_q <= '0;
      octl_q <= '0;
    end else begin
      srst_q <= wr_cstat && reg_wdata[BIT_SRST];
      if (wr_cstat) auto_q <= reg_wdata[BIT_AUTO];
      if (wr_ictl)  ictl_q <= reg_wdata;
      if (wr_octl)  octl_q <= reg_wdata;
    end
  end

  // per-source status and mask bits
  for (genvar s = 0; s < NSRC; s++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        status_q[s] <= 1'b0;
        mask_q[s]   <= 1'b0;
      end else begin
        if (srst_q) status_q[s] <= 1'b0;
        else if (done_v[s]) status_q[s] <= 1'b1;
        else if (wr_cstat && reg_wdata[s]) status_q[s] <= 1'b0;

        if (auto_q && done_v[s]) mask_q[s] <= 1'b0;
        else if (wr_mask) mask_q[s] <= reg_wdata[s];
      end
    end
  end

  assign irq = |(status_q & ~mask_q);

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_CSTAT: begin
        reg_rdata[NSRC-1:0] = status_q;
        reg_rdata[BIT_AUTO] = auto_q;
      end
      SEL_ID:   reg_rdata = ID_VALUE;
      SEL_MASK: reg_rdata[NSRC-1:0] = mask_q;
      SEL_ICTL: reg_rdata = ictl_q;
      SEL_ICNT: reg_rdata = i_cnt;
      SEL_OCTL: reg_rdata = octl_q;
      SEL_OCNT: reg_rdata = o_cnt;
      default:  reg_rdata = '0;
    endcase
  end

  // R9: completion under auto-unmask leaves the mask bit clear
  a_r9_auto_unmask: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_q && i_done) |=> !mask_q[0]);
  // R10: soft reset empties the output side and zeroes counts and status
  a_r10_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (i_cnt == '0 && o_cnt == '0 && status_q == '0 && !out_valid));
  // R7: a completion is visible in status on the next cycle
  a_r7_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (o_done && !srst_q) |=> status_q[1]);
endmodule

// File: tb/host_buf_ctrl_test.sv
`timescale 1ns/1ps
module host_buf_ctrl_test;
  localparam int DEPTH = 8;
  localparam logic [31:0] IDV = 32'h0C0F_FEE1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        in_valid = 1'b0, in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid, out_ready = 1'b0;
  logic [31:0] out_data;
  logic        dreq_in, dreq_out, irq;
  logic        int_wr_en, int_rd_en;
  logic [15:0] int_wr_addr, int_rd_addr;
  logic [31:0] int_wr_data, int_rd_data;

  int checks = 0, errors = 0;
  int wn = 0;
  logic [15:0] la [64];
  logic [31:0] ld [64];

  always #2 clk = ~clk;

  function automatic logic [31:0] rd_fn(input logic [15:0] a);
    return {16'h5A5A, a ^ 16'h0F0F};
  endfunction
  function automatic logic [15:0] nxt(input logic [15:0] a, input logic [15:0] m);
    return (a & ~m) | ((a + 16'd1) & m);
  endfunction

  assign int_rd_data = rd_fn(int_rd_addr);

  host_buf_ctrl #(.DEPTH(DEPTH), .ADDR_W(16), .ID_VALUE(IDV)) uut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .dreq_in(dreq_in), .dreq_out(dreq_out), .irq(irq),
    .int_wr_en(int_wr_en), .int_wr_addr(int_wr_addr), .int_wr_data(int_wr_data),
    .int_rd_en(int_rd_en), .int_rd_addr(int_rd_addr), .int_rd_data(int_rd_data)
  );

  always @(negedge clk) begin
    if (rst_n && int_wr_en && wn < 64) begin
      la[wn] = int_wr_addr;
      ld[wn] = int_wr_data;
      wn = wn + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_sel = s; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] v);
    @(negedge clk);
    reg_sel = s;
    #1 v = reg_rdata;
  endtask

  task automatic push(input int n, input logic [31:0] base, output int got);
    int tries = 0;
    got = 0;
    while (got < n && tries < 50) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data = base + 32'(got);
      #1;
      if (in_ready) begin
        @(posedge clk);
        got++;
      end
      tries++;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_wn(input int n);
    for (int k = 0; k < 100 && wn < n; k++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [15:0] a;
    logic [15:0] masks [3];
    logic [15:0] starts [2];
    int got;
    masks[0] = 16'hFFFF; masks[1] = 16'h0003; masks[2] = 16'h0007;
    starts[0] = 16'h1230; starts[1] = 16'hFFF6;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state: R1 R2 R3 R8
    #1;
    chk(dreq_in && in_ready, "R2 reset dreq_in", {31'd0, dreq_in}, 32'd1);
    chk(!dreq_out && !out_valid, "R3 reset dreq_out", {31'd0, dreq_out}, 32'd0);
    chk(!irq, "R8 reset irq", {31'd0, irq}, 32'd0);
    rd(3'd1, v); chk(v == IDV, "R1 id", v, IDV);
    rd(3'd0, v); chk(v == 0, "R1 cstat reset", v, 0);
    wr(3'd5, 32'h00FF_0ABC); rd(3'd5, v);
    chk(v == 32'h00FF_0ABC, "R1 octl readback", v, 32'h00FF_0ABC);

    // input sweep: R4 R5 R7 R8
    for (int mi = 0; mi < 3; mi++) begin
      for (int si = 0; si < 2; si++) begin
        wr(3'd3, {masks[mi], starts[si]});
        wn = 0;
        wr(3'd4, 32'd20);
        push(20, {8'hA0 + 8'(mi * 2 + si), 24'd0}, got);
        wait_wn(20);
        chk(wn == 20, "R4 word count", 32'(wn), 32'd20);
        a = starts[si];
        for (int i = 0; i < 20; i++) begin
          chk(la[i] == a, "R5 address", {16'd0, la[i]}, {16'd0, a});
          chk(ld[i] == ({8'hA0 + 8'(mi * 2 + si), 24'd0} + 32'(i)), "R4 data", ld[i],
              {8'hA0 + 8'(mi * 2 + si), 24'd0} + 32'(i));
          a = nxt(a, masks[mi]);
        end
        rd(3'd4, v); chk(v == 0, "R7 count zero", v, 0);
        rd(3'd0, v); chk(v[0] == 1'b1, "R7 in done", v, 32'd1);
        chk(irq, "R8 irq unmasked", {31'd0, irq}, 32'd1);
        wr(3'd0, 32'd1);
        rd(3'd0, v); chk(v[0] == 1'b0, "R7 w1c", v, 0);
        chk(!irq, "R8 irq cleared", {31'd0, irq}, 32'd0);
      end
    end

    // fill with zero count: R2 R4
    wr(3'd4, 32'd0);
    wn = 0;
    push(DEPTH, 32'h7700_0000, got);
    #1;
    chk(got == DEPTH, "R2 accepts depth", 32'(got), 32'(DEPTH));
    chk(!in_ready && !dreq_in, "R2 full drops dreq_in", {31'd0, dreq_in}, 32'd0);
    chk(wn == 0, "R4 stall on zero count", 32'(wn), 32'd0);
    wr(3'd3, 32'hFFFF_0040);
    wr(3'd4, DEPTH);
    wait_wn(DEPTH);
    chk(wn == DEPTH, "R4 drain count", 32'(wn), 32'(DEPTH));
    for (int i = 0; i < DEPTH; i++)
      chk(ld[i] == 32'h7700_0000 + 32'(i) && la[i] == 16'h0040 + 16'(i), "R4 drain order",
          ld[i], 32'h7700_0000 + 32'(i));
    chk(dreq_in, "R2 dreq_in back", {31'd0, dreq_in}, 32'd1);
    wr(3'd0, 32'd1);

    // output path: R3 R6 R7
    out_ready = 1'b0;
    wr(3'd5, 32'h0007_0010);
    wr(3'd6, 32'd20);
    repeat (20) @(negedge clk);
    #1;
    chk(out_valid && dreq_out, "R3 dreq_out with data", {31'd0, dreq_out}, 32'd1);
    rd(3'd6, v); chk(v == 32'd20 - DEPTH, "R6 read pauses when full", v, 32'd20 - DEPTH);
    a = 16'h0010;
    for (int i = 0; i < 20; i++) begin
      int t = 0;
      @(negedge clk);
      while (!out_valid && t < 50) begin @(negedge clk); t++; end
      chk(out_data == rd_fn(a), "R3 R6 output word", out_data, rd_fn(a));
      out_ready = 1'b1;
      @(posedge clk);
      #1 out_ready = 1'b0;
      a = nxt(a, 16'h0007);
    end
    repeat (2) @(negedge clk);
    #1;
    chk(!dreq_out, "R3 dreq_out empty", {31'd0, dreq_out}, 32'd0);
    rd(3'd0, v); chk(v[1] == 1'b1, "R7 out done", v, 32'd2);
    wr(3'd0, 32'd3);

    // masked interrupt: R8
    wr(3'd2, 32'd3);
    wr(3'd4, 32'd3);
    wn = 0;
    push(3, 32'h1, got);
    wait_wn(3);
    rd(3'd0, v); chk(v[0] == 1'b1, "R8 status set while masked", v, 32'd1);
    chk(!irq, "R8 masked irq low", {31'd0, irq}, 32'd0);
    wr(3'd0, 32'd1);

    // auto-unmask: R9
    wr(3'd0, 32'h100);
    wr(3'd2, 32'd3);
    wr(3'd4, 32'd2);
    wn = 0;
    push(2, 32'h2, got);
    wait_wn(2);
    rd(3'd2, v); chk(v == 32'd2, "R9 in mask auto cleared", v, 32'd2);
    chk(irq, "R9 irq after unmask", {31'd0, irq}, 32'd1);
    wr(3'd0, 32'h103);

    // soft reset: R10
    wr(3'd0, 32'd0);
    wr(3'd2, 32'd1);
    wr(3'd4, 32'd0);
    push(5, 32'h9, got);
    wr(3'd6, 32'd30);
    repeat (12) @(negedge clk);
    wr(3'd0, 32'h8000_0000);
    repeat (2) @(negedge clk);
    #1;
    chk(!out_valid && !dreq_out, "R10 out fifo emptied", {31'd0, out_valid}, 32'd0);
    rd(3'd6, v); chk(v == 0, "R10 out count zero", v, 0);
    rd(3'd4, v); chk(v == 0, "R10 in count zero", v, 0);
    rd(3'd0, v); chk(v == 0, "R10 status clear", v, 0);
    rd(3'd2, v); chk(v == 32'd1, "R10 mask kept", v, 32'd1);
    rd(3'd1, v); chk(v == IDV, "R10 id kept", v, IDV);
    rd(3'd5, v); chk(v == 32'h0007_0010, "R10 ctl kept", v, 32'h0007_0010);
    push(DEPTH, 32'h0, got);
    chk(got == DEPTH, "R10 in fifo emptied", 32'(got), 32'(DEPTH));

    finish_run();
  end
endmodule